// File: doc/BRIEF.md
# SPI register port with byte-wise commit

This block is an SPI slave (mode 0: clock idles low, the master samples on the rising edge) that serves a register file of 32 locations. Locations 0 to 7 hold 8-bit registers, 8 to 15 hold 16-bit registers, and 16 to 31 hold 24-bit registers. Each transaction begins with an 8-bit access byte that carries a direction flag and a register address. The data bits of the addressed register follow, most significant bit first.

On a write, every data byte is stored in the register as soon as its eighth bit has arrived, starting with the top byte. If the master raises chip-select partway through a multibyte write, the bytes that fully arrived keep their new values and the rest of the register is left as it was. On a read, the register is shifted out on a data line that is high impedance whenever chip-select is high. A one-cycle strobe reports that the data register has been read to its last bit.

The SPI pins are sampled through synchronizers in the system clock domain. SCLK high and low times must each last at least four system clock cycles.

Top module: `spi_regport`

## Requirements
- R1: `spi_miso` is high impedance while `spi_csn` is high, and it is driven to a 0 or 1 level while `spi_csn` is low.
- R2: `spi_miso` changes only after a falling edge of `spi_sclk`, and stays stable while `spi_sclk` is high.
- R3: The access byte is sent MSB first. Bit 7 set means read and bit 7 clear means write. Bits 5:1 carry the register address, and bits 6 and 0 are ignored. Addresses 0-7 select 8-bit registers, 8-15 select 16-bit registers, and 16-31 select 24-bit registers.
- R4: During a write, each completed group of 8 data bits is stored into the next byte of the register, top byte first. A 24-bit write that ends after 24 SCLKs therefore changes bits 23:8 and leaves bits 7:0 as they were.
- R5: A write transaction that ends after 15 or fewer SCLKs leaves the register unchanged.
- R6: A 24-bit write that ends after exactly 16 SCLKs updates only bits 23:16 of the register.
- R7: A full write takes 8 plus the register width in SCLKs (32 for a 24-bit register). Any SCLKs beyond that are ignored, and no other register is changed.
- R8: A read shifts the addressed register out MSB first, one bit per SCLK after the access byte. Exactly the width of that register is sent.
- R9: `rd_done` pulses high for one system clock cycle after the rising SCLK edge of the last bit of a read of the data register (address 16). It does not pulse for a read that stops early or for a read of any other register.
- R10: Raising `spi_csn` ends the transaction. The next transaction starts again with an access byte, whatever bit count the previous one reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_csn | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, high impedance when not selected |
| rd_done | output | 1 | One-cycle strobe: data register fully read |

## Verification
The hardest case to reach from the ports is a write that is cut off partway through. The register can be left in a state where some bytes are new and others are old, and that state only shows up through a later read. The bench first writes a known pattern with a full transaction. It then aborts a second write after 15, 16 or 24 SCLKs by raising chip-select, and reads the register back to see which bytes changed. The strobe is tested in the same way, with a data-register read cut one bit short of its full length.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int ADDR_W    = 5;
  localparam int MAX_BYTES = 3;
  localparam int REG_W     = 8 * MAX_BYTES;
  localparam int LANE_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int NB_W      = $clog2(MAX_BYTES + 1);
  localparam int ONE_BYTE_END = 8;
  localparam int TWO_BYTE_END = 16;

  // Number of data bytes held at a given register address.
  function automatic logic [NB_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    if (int'(a) < ONE_BYTE_END)      return NB_W'(1);
    else if (int'(a) < TWO_BYTE_END) return NB_W'(2);
    else                             return NB_W'(MAX_BYTES);
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic mosi_in,
  output logic csn_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  // bit 2: sclk, bit 1: csn, bit 0: mosi
  localparam logic [2:0] IDLE = 3'b010;

  logic [2:0] pipe [STAGES];
  logic       sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
      sclk_d <= 1'b0;
    end else begin
      pipe[0] <= {sclk_in, csn_in, mosi_in};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_d <= pipe[STAGES-1][2];
    end
  end

  assign csn_s     = pipe[STAGES-1][1];
  assign mosi_s    = pipe[STAGES-1][0];
  assign sclk_rise = pipe[STAGES-1][2] & ~sclk_d;
  assign sclk_fall = ~pipe[STAGES-1][2] & sclk_d;
endmodule

// File: rtl/spi_regport_mem.sv
module spi_regport_mem
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wbyte,
  output logic [REG_W-1:0]  rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  // One byte-wide array per lane so each maps onto its own block RAM.
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    logic [7:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (we && int'(lane) == g) store[addr] <= wbyte;
      rdata[g*8 +: 8] <= store[addr];
    end
  end

  AST_LANE_IN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(lane) < int'(reg_bytes(addr)))); // R4
endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int DATA_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [REG_W-1:0]  rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [LANE_W-1:0] mem_lane,
  output logic [7:0]        mem_byte,
  output logic              miso_q,
  output logic              rd_done
);
  localparam int CNT_W = $clog2(8 + 8 * MAX_BYTES) + 1;

  logic [CNT_W-1:0] bitcnt;
  logic [CNT_W-1:0] tx_cnt;
  logic [6:0]       sh;
  logic             is_read;
  logic [NB_W-1:0]  nbytes;
  logic [REG_W-1:0] tx_sh;
  logic [7:0]       byte_now;
  logic [CNT_W-4:0] idx;
  logic [CNT_W-1:0] total_bits;
  logic [CNT_W-1:0] last_bit;
  logic [REG_W-1:0] rd_al;

  assign byte_now   = {sh, mosi_s};
  assign idx        = bitcnt[CNT_W-1:3] - 1'b1;
  assign total_bits = CNT_W'(8 * int'(nbytes));
  assign last_bit   = CNT_W'(8 * int'(nbytes) + 7);
  assign rd_al      = rd_data << (8 * (MAX_BYTES - int'(nbytes)));

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      bitcnt   <= '0;
      tx_cnt   <= '0;
      sh       <= '0;
      is_read  <= 1'b0;
      nbytes   <= NB_W'(1);
      reg_addr <= '0;
      tx_sh    <= '0;
      miso_q   <= 1'b0;
      mem_we   <= 1'b0;
      mem_lane <= '0;
      mem_byte <= '0;
      rd_done  <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rd_done <= 1'b0;
      if (sclk_rise) begin
        sh <= byte_now[6:0];
        if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CNT_W'(7)) begin
          is_read  <= sh[6];
          reg_addr <= sh[4:0];
          nbytes   <= reg_bytes(sh[4:0]);
        end else if (bitcnt >= CNT_W'(8) && bitcnt[2:0] == 3'd7) begin
          if (!is_read && int'(idx) < int'(nbytes)) begin
            mem_we   <= 1'b1;
            mem_lane <= LANE_W'(int'(nbytes) - 1 - int'(idx));
            mem_byte <= byte_now;
          end
          if (is_read && reg_addr == ADDR_W'(DATA_ADDR) && bitcnt == last_bit)
            rd_done <= 1'b1;
        end
      end
      if (sclk_fall && is_read && bitcnt >= CNT_W'(8)) begin
        if (tx_cnt < total_bits) begin
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_cnt == '0) begin
            miso_q <= rd_al[REG_W-1];
            tx_sh  <= rd_al << 1;
          end else begin
            miso_q <= tx_sh[REG_W-1];
            tx_sh  <= tx_sh << 1;
          end
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bitcnt >= CNT_W'(16))); // R5
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !csn_s) |=> $stable(miso_q)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done); // R9
  AST_CS_RESTART: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> (bitcnt == '0 && !is_read)); // R10
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int DATA_ADDR   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic rd_done
);
  logic              csn_s, mosi_s, sclk_rise, sclk_fall;
  logic              mem_we, miso_q;
  logic [ADDR_W-1:0] reg_addr;
  logic [LANE_W-1:0] mem_lane;
  logic [7:0]        mem_byte;
  logic [REG_W-1:0]  rd_data;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(spi_sclk), .csn_in(spi_csn), .mosi_in(spi_mosi),
    .csn_s(csn_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  spi_regport_ctrl #(.DATA_ADDR(DATA_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .csn_s(csn_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .rd_data(rd_data), .mem_we(mem_we), .reg_addr(reg_addr),
    .mem_lane(mem_lane), .mem_byte(mem_byte), .miso_q(miso_q), .rd_done(rd_done)
  );

  spi_regport_mem u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .addr(reg_addr), .lane(mem_lane),
    .wbyte(mem_byte), .rdata(rd_data)
  );

  assign spi_miso = spi_csn ? 1'bz : miso_q;
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_csn = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic rd_done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int stab_err = 0;
  logic first_bit;

  always #10 clk = ~clk;

  spi_regport u_dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rd_done(rd_done)
  );

  always @(negedge clk) if (rd_done === 1'b1) done_cnt++;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic spi_xfer(input logic [7:0] acc, input logic [23:0] wd, input int nclk,
                          output logic [23:0] rd);
    logic a, b;
    rd = '0;
    spi_csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      if (i < 8) spi_mosi = acc[7-i];
      else if (i < 32) spi_mosi = wd[31-i];
      else spi_mosi = 1'b0;
      wait_clk(HALF - 1);
      @(negedge clk); a = spi_miso;
      if (i == 8) first_bit = a;
      if (i >= 8 && i < 32) rd[31-i] = a;
      @(posedge clk); #2 spi_sclk = 1'b1;
      wait_clk(HALF - 1);
      @(negedge clk); b = spi_miso;
      if (a !== b) stab_err++;
      @(posedge clk); #2 spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_csn = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(12);
  endtask

  function automatic logic [7:0] acc_byte(input logic rd, input logic [4:0] a);
    return {rd, 1'b0, a, 1'b0};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [23:0] d, input int n);
    logic [23:0] dummy;
    spi_xfer(acc_byte(1'b0, a), d, n, dummy);
  endtask

  task automatic rdreg(input logic [4:0] a, input int n, output logic [23:0] v);
    spi_xfer(acc_byte(1'b1, a), 24'h0, n, v);
  endtask

  task automatic t_reset;
    chk("R1 miso hi-z in reset/idle", {23'b0, spi_miso}, {23'b0, 1'bz});
    chk("R9 no strobe after reset", {23'b0, rd_done}, 24'h0);
  endtask

  task automatic t_full24;
    logic [23:0] v;
    int d0;
    wr(5'd16, 24'hA5C33C, 32);
    d0 = done_cnt;
    rdreg(5'd16, 32, v);
    chk("R8 read back 24-bit data reg", v, 24'hA5C33C);
    chk("R1 miso driven while selected", {23'b0, first_bit}, 24'h1);
    chk("R9 strobe once on full data read", 24'(done_cnt - d0), 24'd1);
    chk("R1 miso hi-z after deselect", {23'b0, spi_miso}, {23'b0, 1'bz});
  endtask

  task automatic t_widths;
    logic [23:0] v;
    wr(5'd3, 24'h5A0000, 16);
    rdreg(5'd3, 16, v);
    chk("R3 8-bit register read", v, 24'h5A0000);
    wr(5'd9, 24'h123400, 24);
    rdreg(5'd9, 24, v);
    chk("R3 16-bit register read", v, 24'h123400);
    rdreg(5'd9, 32, v);
    chk("R8 only register width shifted", v, 24'h123400);
  endtask

  task automatic t_abort;
    logic [23:0] v;
    wr(5'd20, 24'h111111, 32);
    wr(5'd20, 24'hFFFFFF, 15);
    rdreg(5'd20, 32, v);
    chk("R5 15-SCLK write no change", v, 24'h111111);
    wr(5'd20, 24'hABCDEF, 16);
    rdreg(5'd20, 32, v);
    chk("R6 16-SCLK write top byte only", v, 24'hAB1111);
    wr(5'd20, 24'h222222, 24);
    rdreg(5'd20, 32, v);
    chk("R4 24-SCLK write two top bytes", v, 24'h222211);
  endtask

  task automatic t_extra;
    logic [23:0] v;
    wr(5'd9, 24'hBEEF77, 40);
    rdreg(5'd9, 24, v);
    chk("R7 extra SCLKs ignored on 16-bit", v, 24'hBEEF00);
    wr(5'd3, 24'h7799AA, 32);
    rdreg(5'd3, 16, v);
    chk("R7 8-bit write with extra bits", v, 24'h770000);
    rdreg(5'd9, 24, v);
    chk("R7 neighbour register untouched", v, 24'hBEEF00);
  endtask

  task automatic t_done;
    logic [23:0] v;
    int d0;
    d0 = done_cnt;
    rdreg(5'd16, 31, v);
    chk("R9 no strobe on short data read", 24'(done_cnt - d0), 24'd0);
    rdreg(5'd20, 32, v);
    chk("R9 no strobe on other register", 24'(done_cnt - d0), 24'd0);
  endtask

  task automatic t_restart;
    logic [23:0] v;
    wr(5'd5, 24'hFF0000, 5);
    wr(5'd5, 24'h3C0000, 16);
    rdreg(5'd5, 16, v);
    chk("R10 new access byte after abort", v, 24'h3C0000);
    chk("R2 miso stable while sclk high", 24'(stab_err), 24'd0);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_full24();
    t_widths();
    t_abort();
    t_extra();
    t_done();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule